// File: doc/BRIEF.md
# Phase-Locked Master/Slave PWM Timer Pair

This block holds two up-counting PWM timers that run from one clock. The master timer sets the PWM period. The slave timer follows the master through a one-cycle trigger link. Each timer has a period register and a set of compare registers. Software writes all of them through a preload stage, and a timer copies the preload values into its active registers only on an update event. Each compare channel drives one PWM line. That line is high while the counter is below the channel's active compare value. Any centring of the pulses comes from the compare values, because neither counter ever counts down.

The master sends a single-cycle pulse on its trigger output. Software chooses the source of that pulse: either the start of the master's counting or each master update event. The slave can run free, start counting on the trigger, or restart on every trigger. In the restart mode, the slave period is left at all ones. The master update pulse then clears the slave and reloads its preloads, so the slave count stays a fixed one cycle behind the master. This holds even when the period is rewritten while the timers run, and even for very short periods.

Software accesses the block through a simple write port. Registers, by `wr_addr`:
- 0: master control. Bit 0 enables counting, bit 1 disables updates, bit 2 selects the trigger source (0 = start of counting, 1 = update).
- 1: master period preload.
- 2: master event. Bit 0 forces an update.
- 3: slave control. Bit 0 enables counting, bit 1 disables updates, bits 3:2 select the slave mode (0 = free, 1 = start on trigger, 2 = restart on trigger).
- 4: slave period preload.
- 5: slave event. Bit 0 forces an update.
- 8 + n: master compare preload for channel n.
- 12 + n: slave compare preload for channel n.

Top module: `psync_pair`

## Requirements
- R1: After reset, both counts are 0, both timers are stopped, every PWM line is low and `trig_out` is low.
- R2: A running counter adds one each clock and goes to 0 on the clock after it equals the active period, so one round lasts period+1 cycles. The count never exceeds the active period.
- R3: A period write goes to the preload register only. The active period changes at the next update event, so the round in progress ends at the old period.
- R4: While the update-disable bit (control bit 1) is set, no update event occurs and the active period holds. The counter still wraps at the old period, and the buffered value is taken at the first wrap after the bit is cleared.
- R5: Writing 1 to the event register's bit 0 clears the counter on the next clock and, with updates enabled, loads the buffered period at once.
- R6: A period write that falls in the same cycle as an update event takes effect at that update.
- R7: A PWM line is high exactly while its timer's count is below that channel's active compare value. Compare writes are buffered and load only on update.
- R8: With trigger source 0, `trig_out` is high for exactly one cycle, the second cycle after the master enable write takes effect.
- R9: In slave mode 1, the stopped slave starts counting in the cycle it sees `trig_out`. From then on the slave count equals the master count of the previous cycle.
- R10: In slave mode 2, each `trig_out` pulse clears the slave count, loads the slave preloads and starts the slave if it was stopped. With trigger source 1, the slave count equals the previous-cycle master count across on-the-fly period changes, including periods 0 and 1.
- R11: With trigger source 1, `trig_out` is high in the cycle after each master update event, and at no other time while the master runs without forced updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both timers |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (16) | Write data |
| master_pwm | output | NCH (2) | PWM lines of the master, one per channel |
| slave_pwm | output | NCH (2) | PWM lines of the slave, one per channel |
| master_count | output | CW (16) | Master counter value |
| slave_count | output | CW (16) | Slave counter value |
| trig_out | output | 1 | Registered master trigger pulse |

## Verification
A period write can land in the same cycle as the counter's wrap. The design then has to decide whether the new value or the old one enters the active register. The bench provokes this by waiting until the master count equals the active period and issuing the write in that same cycle. It then judges the outcome by measuring the next round's length, which must follow the new value. A second collision is a master update pulse arriving at the slave while the slave's own counter is about to advance. Restart mode produces this on every round, and the bench compares the slave count with the master count of the previous cycle on every clock while the period is rewritten down to 0.

// File: rtl/psync_pkg.sv
// Shared types and register addresses for the master/slave PWM timer pair.
// Assumes an address field of at least 4 bits and at most 4 compare channels.
package psync_pkg;

    typedef enum logic [1:0] {
        SLV_FREE    = 2'd0,
        SLV_TRIG    = 2'd1,
        SLV_RESTART = 2'd2,
        SLV_RSVD    = 2'd3
    } slave_mode_e;

    // Per-timer control strobes produced by the register decoder
    typedef struct packed {
        logic en_we;
        logic en_val;
        logic udis;
        logic force_ug;
        logic per_we;
    } tmr_ctl_t;

    localparam int unsigned ADR_M_CTRL = 0;
    localparam int unsigned ADR_M_PER  = 1;
    localparam int unsigned ADR_M_EVT  = 2;
    localparam int unsigned ADR_S_CTRL = 3;
    localparam int unsigned ADR_S_PER  = 4;
    localparam int unsigned ADR_S_EVT  = 5;
    localparam int unsigned ADR_M_CMP  = 8;
    localparam int unsigned ADR_S_CMP  = 12;

endpackage

// File: rtl/psync_regs.sv
// Register decoder: turns the write port into control strobes for both timers.
// It also holds the update-disable bits, the trigger source and the slave mode.
// Assumes NCH <= 4 so compare addresses do not overlap.
module psync_regs
    import psync_pkg::*;
#(
    parameter int AW  = 4,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [3:0]     wr_bits,
    output tmr_ctl_t       m_ctl,
    output tmr_ctl_t       s_ctl,
    output logic [NCH-1:0] m_cmp_we,
    output logic [NCH-1:0] s_cmp_we,
    output logic           src_upd,
    output slave_mode_e    s_mode
);
    localparam logic [AW-1:0] A_MC = AW'(ADR_M_CTRL);
    localparam logic [AW-1:0] A_MP = AW'(ADR_M_PER);
    localparam logic [AW-1:0] A_ME = AW'(ADR_M_EVT);
    localparam logic [AW-1:0] A_SC = AW'(ADR_S_CTRL);
    localparam logic [AW-1:0] A_SP = AW'(ADR_S_PER);
    localparam logic [AW-1:0] A_SE = AW'(ADR_S_EVT);

    logic m_udis_q, s_udis_q;
    logic wr_mc, wr_sc;

    assign wr_mc = wr_en && (wr_addr == A_MC);
    assign wr_sc = wr_en && (wr_addr == A_SC);

    // Holds the persistent control fields written through the control addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_udis_q <= 1'b0;
            s_udis_q <= 1'b0;
            src_upd  <= 1'b0;
            s_mode   <= SLV_FREE;
        end else begin
            if (wr_mc) begin
                m_udis_q <= wr_bits[1];
                src_upd  <= wr_bits[2];
            end
            if (wr_sc) begin
                s_udis_q <= wr_bits[1];
                s_mode   <= slave_mode_e'(wr_bits[3:2]);
            end
        end
    end

    // Builds the single-cycle strobes for each timer
    always_comb begin
        m_ctl.en_we    = wr_mc;
        m_ctl.en_val   = wr_bits[0];
        m_ctl.udis     = m_udis_q;
        m_ctl.force_ug = wr_en && (wr_addr == A_ME) && wr_bits[0];
        m_ctl.per_we   = wr_en && (wr_addr == A_MP);
        s_ctl.en_we    = wr_sc;
        s_ctl.en_val   = wr_bits[0];
        s_ctl.udis     = s_udis_q;
        s_ctl.force_ug = wr_en && (wr_addr == A_SE) && wr_bits[0];
        s_ctl.per_we   = wr_en && (wr_addr == A_SP);
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp_dec
        localparam logic [AW-1:0] A_MCMP = AW'(ADR_M_CMP + ch);
        localparam logic [AW-1:0] A_SCMP = AW'(ADR_S_CMP + ch);
        // Compare write strobe for this channel on either timer
        always_comb begin
            m_cmp_we[ch] = wr_en && (wr_addr == A_MCMP);
            s_cmp_we[ch] = wr_en && (wr_addr == A_SCMP);
        end
    end

endmodule

// File: rtl/psync_timer.sv
// One up-counting PWM timer. The period and compare values pass through a
// preload stage and load on an update event. An update event is a wrap, a
// forced update or a hardware restart, and update-disable masks it. The
// counter still clears on a wrap, a force or a restart. A write that
// coincides with an update is forwarded into the active registers.
module psync_timer
    import psync_pkg::*;
#(
    parameter int             CW      = 16,
    parameter int             NCH     = 2,
    parameter logic [CW-1:0]  RST_PER = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_ctl_t            ctl,
    input  logic [CW-1:0]       wdata,
    input  logic [NCH-1:0]      cmp_we,
    input  logic                hw_start,
    input  logic                hw_reset,
    output logic [CW-1:0]       cnt,
    output logic                run,
    output logic                uev,
    output logic [CW-1:0]       per_act,
    output logic [NCH-1:0]      pwm
);
    logic          en_q;
    logic [CW-1:0] per_pre, per_pre_nx;
    logic          wrap, clr;

    assign run        = en_q | hw_start;
    assign wrap       = run && (cnt == per_act);
    assign clr        = wrap | ctl.force_ug | hw_reset;
    assign uev        = clr && !ctl.udis;
    assign per_pre_nx = ctl.per_we ? wdata : per_pre;

    // Enable bit: a hardware start overrides a software write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)           en_q <= 1'b0;
        else if (hw_start)    en_q <= 1'b1;
        else if (ctl.en_we)   en_q <= ctl.en_val;
    end

    // Counter: clear on wrap, force or restart, otherwise count while running
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
    end

    // Period preload and active registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_pre <= RST_PER;
            per_act <= RST_PER;
        end else begin
            per_pre <= per_pre_nx;
            if (uev) per_act <= per_pre_nx;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CW-1:0] cmp_pre, cmp_act, cmp_pre_nx;
        assign cmp_pre_nx = cmp_we[ch] ? wdata : cmp_pre;
        // Compare preload and active registers for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_pre <= '0;
                cmp_act <= '0;
            end else begin
                cmp_pre <= cmp_pre_nx;
                if (uev) cmp_act <= cmp_pre_nx;
            end
        end
        assign pwm[ch] = (cnt < cmp_act);
    end

endmodule

// File: rtl/psync_trigger.sv
// Master trigger generator: one register stage that emits a one-cycle pulse,
// either on the master's first running cycle or on each master update event.
module psync_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic src_upd,
    input  logic m_run,
    input  logic m_uev,
    output logic trig
);
    logic run_d;

    // Delayed run flag and the registered trigger pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_d <= 1'b0;
            trig  <= 1'b0;
        end else begin
            run_d <= m_run;
            trig  <= src_upd ? m_uev : (m_run && !run_d);
        end
    end

endmodule

// File: rtl/psync_pair.sv
// Top of the master/slave PWM timer pair. The master trigger reaches the slave
// through exactly one register, so restart mode keeps a one-cycle lag.
module psync_pair
    import psync_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 2,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] master_pwm,
    output logic [NCH-1:0] slave_pwm,
    output logic [CW-1:0]  master_count,
    output logic [CW-1:0]  slave_count,
    output logic           trig_out
);
    tmr_ctl_t       m_ctl, s_ctl;
    logic [NCH-1:0] m_cmp_we, s_cmp_we;
    logic           src_upd;
    slave_mode_e    s_mode;
    logic           m_run, m_uev, s_run, s_uev;
    logic [CW-1:0]  m_per, s_per;
    logic           s_start, s_restart;

    psync_regs #(.AW(AW), .NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bits(wr_data[3:0]), .m_ctl(m_ctl), .s_ctl(s_ctl),
        .m_cmp_we(m_cmp_we), .s_cmp_we(s_cmp_we),
        .src_upd(src_upd), .s_mode(s_mode)
    );

    psync_timer #(.CW(CW), .NCH(NCH)) u_master (
        .clk(clk), .rst_n(rst_n), .ctl(m_ctl), .wdata(wr_data),
        .cmp_we(m_cmp_we), .hw_start(1'b0), .hw_reset(1'b0),
        .cnt(master_count), .run(m_run), .uev(m_uev),
        .per_act(m_per), .pwm(master_pwm)
    );

    psync_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .src_upd(src_upd),
        .m_run(m_run), .m_uev(m_uev), .trig(trig_out)
    );

    // Slave-mode decode of the incoming trigger pulse
    always_comb begin
        s_start   = trig_out && (s_mode == SLV_TRIG || s_mode == SLV_RESTART);
        s_restart = trig_out && (s_mode == SLV_RESTART);
    end

    psync_timer #(.CW(CW), .NCH(NCH)) u_slave (
        .clk(clk), .rst_n(rst_n), .ctl(s_ctl), .wdata(wr_data),
        .cmp_we(s_cmp_we), .hw_start(s_start), .hw_reset(s_restart),
        .cnt(slave_count), .run(s_run), .uev(s_uev),
        .per_act(s_per), .pwm(slave_pwm)
    );

endmodule

// File: rtl/psync_pair_chk.sv
// Property checker for psync_pair, attached through bind below.
module psync_pair_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] m_cnt,
    input logic [CW-1:0] s_cnt,
    input logic [CW-1:0] m_per,
    input logic [CW-1:0] s_per,
    input logic          m_uev,
    input logic          s_uev,
    input logic          m_udis,
    input logic          m_force,
    input logic          trig,
    input logic          src_upd,
    input logic          s_restart_mode,
    input logic          s_run
);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cnt <= m_per) && (s_cnt <= s_per));

    assert_per_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !m_uev |=> $stable(m_per));

    assert_udis_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_udis |=> $stable(m_per));

    assert_force_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_force |=> (m_cnt == '0));

    assert_slave_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_restart_mode && trig) |=> (s_cnt == '0));

    assert_slave_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_restart_mode && trig) |-> (s_run && s_uev));

    assert_upd_trig_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_uev && src_upd) |=> trig);
endmodule

bind psync_pair psync_pair_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_cnt(master_count), .s_cnt(slave_count),
    .m_per(m_per), .s_per(s_per), .m_uev(m_uev), .s_uev(s_uev),
    .m_udis(m_ctl.udis), .m_force(m_ctl.force_ug), .trig(trig_out),
    .src_upd(src_upd), .s_restart_mode(s_mode == psync_pkg::SLV_RESTART),
    .s_run(s_run)
);

// File: tb/test_psync_pair.sv
module test_psync_pair;
    localparam int CW = 16, NCH = 2, AW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [NCH-1:0] master_pwm, slave_pwm;
    logic [CW-1:0]  master_count, slave_count;
    logic           trig_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    psync_pair #(.CW(CW), .NCH(NCH), .AW(AW)) i_psync_pair (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Caller is at a negedge; drive one write cycle and return at the next negedge
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_cnt(input int v);
        while (master_count != CW'(v)) @(negedge clk);
    endtask

    // From a negedge with count 0, counts cycles until the count is 0 again
    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (master_count != 0 && n < 70000);
    endtask

    task automatic t_reset();
        check(master_count == 0 && slave_count == 0, "R1 counts", master_count, 0);
        check(master_pwm == 0 && slave_pwm == 0, "R1 pwm", master_pwm, 0);
        check(trig_out == 0, "R1 trig", trig_out, 0);
        repeat (5) @(negedge clk);
        check(master_count == 0 && slave_count == 0, "R1 stopped", master_count, 0);
    endtask

    task automatic t_basic();
        int prev;
        wr(1, 4); wr(8, 2); wr(9, 0); wr(2, 1); wr(0, 1);
        prev = master_count;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check(master_count == CW'(prev == 4 ? 0 : prev + 1), "R2 step", master_count, prev == 4 ? 0 : prev + 1);
            check(master_pwm[0] == (master_count < 2), "R7 ch0", master_pwm[0], master_count < 2);
            check(master_pwm[1] == 1'b0, "R7 ch1", master_pwm[1], 0);
            prev = master_count;
        end
    endtask

    task automatic t_buffer();
        int mx = 0; int n;
        wait_cnt(0);
        wr(8, 1);
        check(master_pwm[0] == 1'b1, "R7 cmp buffered", master_pwm[0], 1);
        wr(1, 7);
        while (master_count != 0) begin
            if (master_count > mx) mx = master_count;
            @(negedge clk);
        end
        check(mx == 4, "R3 old period kept", mx, 4);
        check(master_pwm[0] == 1'b1, "R7 new cmp at 0", master_pwm[0], 1);
        @(negedge clk);
        check(master_pwm[0] == 1'b0, "R7 new cmp at 1", master_pwm[0], 0);
        wait_cnt(0);
        measure(n);
        check(n == 8, "R3 new period", n, 8);
    endtask

    task automatic t_udis();
        int n;
        wr(0, 3); wr(1, 2);
        wait_cnt(0);
        measure(n); check(n == 8, "R4 frozen round 1", n, 8);
        measure(n); check(n == 8, "R4 frozen round 2", n, 8);
        wr(0, 1);
        wait_cnt(0);
        measure(n); check(n == 3, "R4 taken after clear", n, 3);
    endtask

    task automatic t_force();
        int n;
        wait_cnt(0);
        wr(1, 5);
        wr(2, 1);
        check(master_count == 0, "R5 cleared", master_count, 0);
        measure(n); check(n == 6, "R5 loaded", n, 6);
    endtask

    task automatic t_coincide();
        int n;
        wait_cnt(5);
        wr(1, 9);
        check(master_count == 0, "R6 wrap", master_count, 0);
        measure(n); check(n == 10, "R6 forwarded", n, 10);
    endtask

    task automatic t_trig_start();
        int prev;
        do_reset();
        wr(1, 9); wr(2, 1); wr(4, 9); wr(5, 1); wr(3, 4);
        check(slave_count == 0, "R9 idle", slave_count, 0);
        wr(0, 1);
        check(trig_out == 0, "R8 not yet", trig_out, 0);
        for (int i = 0; i < 30; i++) begin
            prev = master_count;
            @(negedge clk);
            check(trig_out == (i == 0), "R8 pulse", trig_out, i == 0);
            check(slave_count == CW'(prev), "R9 lag", slave_count, prev);
        end
    endtask

    task automatic t_restart();
        int prev; int k = 0;
        int pers[8] = '{3, 0, 1, 12, 2, 5, 0, 7};
        do_reset();
        wr(0, 4); wr(12, 3); wr(3, 8); wr(1, 6); wr(2, 1); wr(0, 5);
        @(negedge clk);
        while (!trig_out && k < 40) begin @(negedge clk); k++; end
        check(trig_out == 1'b1, "R11 first pulse", trig_out, 1);
        foreach (pers[j]) begin
            wr(1, pers[j]);
            for (int i = 0; i < 40; i++) begin
                prev = master_count;
                @(negedge clk);
                check(slave_count == CW'(prev), "R10 lag", slave_count, prev);
                check(trig_out == (master_count == 0), "R11 pulse", trig_out, master_count == 0);
                check(slave_pwm[0] == (slave_count < 3), "R10 slave cmp", slave_pwm[0], slave_count < 3);
            end
        end
    endtask

    initial begin
        do_reset();
        t_reset();
        t_basic();
        t_buffer();
        t_udis();
        t_force();
        t_coincide();
        t_trig_start();
        t_restart();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule